// File: doc/BRIEF.md
# SMRAM Visibility Router

This block decides, per memory access, where a 128 KiB system-management RAM area becomes visible. There are two candidate addresses: the legacy graphics window at 0xA0000–0xBFFFF, and a high alias at 0xFEDA0000–0xFEDBFFFF. Both windows, when routed to memory, reach the same DRAM bytes 0xA0000–0xBFFFF. The block returns one of three routes for the access: DRAM, the PCI/VGA path, or unclaimed, which lets other decoders take the access.

Two configuration bytes steer the decision. The SMRAM control byte carries an open bit, a global-enable bit and a lock bit. The extended control byte carries a high-enable bit. An access marked as coming from system-management mode sees the RAM according to global-enable. Any other access sees it only through the open bit. High-enable moves the visible copy from the low window to the high alias. Writes are captured on a clock edge and change the routing from the next cycle. The decode of the access itself is purely combinational.

Top module: `smram_vis`

## Requirements
- R1: After reset the control byte reads 0x02 and the extended byte reads 0x00. A non-SMM access to the low window then routes to PCI/VGA, and one to the high alias is unclaimed.
- R2: Route encoding is 2'b00 unclaimed, 2'b01 DRAM, 2'b10 PCI/VGA; 2'b11 never appears. Any address outside both windows is unclaimed.
- R3: For a non-SMM access with open (control bit 6) clear, the low window routes to PCI/VGA and the high alias is unclaimed.
- R4: For a non-SMM access with open set, the low window routes to DRAM when high-enable (extended bit 7) is 0 and to PCI/VGA when it is 1. The high alias routes to DRAM when high-enable is 1 and is unclaimed when it is 0.
- R5: For an SMM access with global-enable (control bit 3) set, the low window routes to DRAM when high-enable is 0, and the high alias routes to DRAM when high-enable is 1. The window not selected this way falls back to the non-SMM routing of R3/R4.
- R6: For an SMM access with global-enable clear, routing equals the non-SMM routing for the same address and bytes.
- R7: A write selects the control byte (cfgWrSel=0) or the extended byte (cfgWrSel=1). Only control bits 6, 4, 3 and extended bit 7 are writable; every other bit keeps its reset value. The new value, and the routing it implies, is visible in the cycle after the write edge.
- R8: Lock (control bit 4), once set, stays set until reset. While it is set, open reads 0 and cannot be set. A write that sets lock also clears open.
- R9: While lock is set, writes to the control byte leave global-enable unchanged; the extended byte remains writable.
- R10: Window edges are inclusive: 0xA0000, 0xBFFFF, 0xFEDA0000 and 0xFEDBFFFF are inside. 0x9FFFF, 0xC0000, 0xFED9FFFF and 0xFEDC0000 are outside.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrSel | input | 1 | 0 selects the control byte, 1 the extended byte |
| cfgWrData | input | 8 | Write data |
| smmAccess | input | 1 | Current access comes from system-management mode |
| accAddr | input | 32 | Current access address |
| route | output | 2 | Route for the current access |
| ctrlByte | output | 8 | Current control byte value |
| extByte | output | 8 | Current extended byte value |

## Verification
Random streams mix configuration writes with accesses drawn from an address pool. The pool holds every window edge, its outside neighbours, interior points and far-away addresses, under both SMM and non-SMM. This pattern separates the low from the high window and the open path from the global-enable path. Directed sequences walk all eight combinations of open, global-enable and high-enable for both access kinds. These show that high-enable moves the copy between windows, and that SMM without global-enable matches non-SMM. Separate lock sequences try to reopen, to clear lock and to change global-enable. They also show that the extended byte still changes. Periodic resets bring the defaults back.

// File: rtl/smram_vis_pkg.sv
package smram_vis_pkg;

  typedef enum logic [1:0] {
    ROUTE_NONE = 2'b00,
    ROUTE_DRAM = 2'b01,
    ROUTE_PCI  = 2'b10
  } route_e;

  // Strobes from the register side to the address decoder
  typedef struct packed {
    logic lowOpen;   // non-SMM sees DRAM in the low window
    logic highOpen;  // non-SMM sees DRAM at the high alias
    logic lowSmm;    // SMM sees DRAM in the low window
    logic highSmm;   // SMM sees DRAM at the high alias
  } winStrobe_t;

  localparam int OPEN_BIT = 6;
  localparam int LOCK_BIT = 4;
  localparam int GEN_BIT  = 3;
  localparam int HIGH_BIT = 7;

  localparam logic [7:0] CTRL_WMASK = 8'h58;
  localparam logic [7:0] EXT_WMASK  = 8'h80;

endpackage

// File: rtl/smram_ctrl.sv
module smram_ctrl
  import smram_vis_pkg::*;
#(
  parameter logic [7:0] CTRL_DEFAULT = 8'h02,
  parameter logic [7:0] EXT_DEFAULT  = 8'h00
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic [7:0] wrData,
  output logic [7:0] ctrlQ,
  output logic [7:0] extQ,
  output winStrobe_t strobe
);

  logic [7:0] ctrlNext;
  logic       locked;

  assign locked = ctrlQ[LOCK_BIT];

  always_comb begin
    ctrlNext = (ctrlQ & ~CTRL_WMASK) | (wrData & CTRL_WMASK);
    if (wrData[LOCK_BIT]) ctrlNext[OPEN_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= CTRL_DEFAULT;
      extQ  <= EXT_DEFAULT;
    end else if (wrEn) begin
      if (!wrSel) begin
        if (!locked) ctrlQ <= ctrlNext;
      end else begin
        extQ <= (extQ & ~EXT_WMASK) | (wrData & EXT_WMASK);
      end
    end
  end

  always_comb begin
    strobe.lowOpen  = ctrlQ[OPEN_BIT] & ~extQ[HIGH_BIT];
    strobe.highOpen = ctrlQ[OPEN_BIT] &  extQ[HIGH_BIT];
    strobe.lowSmm   = ctrlQ[GEN_BIT]  & ~extQ[HIGH_BIT];
    strobe.highSmm  = ctrlQ[GEN_BIT]  &  extQ[HIGH_BIT];
  end

endmodule

// File: rtl/smram_route.sv
module smram_route
  import smram_vis_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] LOW_BASE  = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFEDA_0000,
  parameter logic [ADDR_W-1:0] WIN_BYTES = 32'h0002_0000
) (
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              smmAccess,
  input  winStrobe_t        strobe,
  output route_e            route
);

  localparam int NWIN = 2;
  localparam logic [NWIN-1:0][ADDR_W-1:0] BASES = {HIGH_BASE, LOW_BASE};

  logic [NWIN-1:0] hit;

  // Wrapping subtract: one compare per window covers both edges
  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic [ADDR_W-1:0] offset;
    assign offset = accAddr - BASES[w];
    assign hit[w] = offset < WIN_BYTES;
  end

  logic lowDram, highDram;
  assign lowDram  = strobe.lowOpen  | (smmAccess & strobe.lowSmm);
  assign highDram = strobe.highOpen | (smmAccess & strobe.highSmm);

  always_comb begin
    route = ROUTE_NONE;
    if (hit[0])      route = lowDram  ? ROUTE_DRAM : ROUTE_PCI;
    else if (hit[1]) route = highDram ? ROUTE_DRAM : ROUTE_NONE;
  end

endmodule

// File: rtl/smram_vis.sv
module smram_vis
  import smram_vis_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] LOW_BASE  = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFEDA_0000,
  parameter logic [ADDR_W-1:0] WIN_BYTES = 32'h0002_0000,
  parameter logic [7:0] CTRL_DEFAULT = 8'h02,
  parameter logic [7:0] EXT_DEFAULT  = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgWrSel,
  input  logic [7:0]        cfgWrData,
  input  logic              smmAccess,
  input  logic [ADDR_W-1:0] accAddr,
  output logic [1:0]        route,
  output logic [7:0]        ctrlByte,
  output logic [7:0]        extByte
);

  winStrobe_t strobe;
  route_e     routeE;

  smram_ctrl #(.CTRL_DEFAULT(CTRL_DEFAULT), .EXT_DEFAULT(EXT_DEFAULT)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(cfgWrEn), .wrSel(cfgWrSel), .wrData(cfgWrData),
    .ctrlQ(ctrlByte), .extQ(extByte), .strobe(strobe)
  );

  smram_route #(.ADDR_W(ADDR_W), .LOW_BASE(LOW_BASE), .HIGH_BASE(HIGH_BASE),
                .WIN_BYTES(WIN_BYTES)) u_route (
    .accAddr(accAddr), .smmAccess(smmAccess), .strobe(strobe), .route(routeE)
  );

  assign route = routeE;

endmodule

// File: rtl/smram_vis_chk.sv
module smram_vis_chk #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] LOW_BASE  = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFEDA_0000,
  parameter logic [ADDR_W-1:0] WIN_BYTES = 32'h0002_0000,
  parameter logic [7:0] CTRL_DEFAULT = 8'h02,
  parameter logic [7:0] EXT_DEFAULT  = 8'h00
) (
  input logic              clk,
  input logic              rstN,
  input logic              smmAccess,
  input logic [ADDR_W-1:0] accAddr,
  input logic [1:0]        route,
  input logic [7:0]        ctrlByte,
  input logic [7:0]        extByte
);

  logic inLow, inHigh;
  assign inLow  = (accAddr >= LOW_BASE)  && (accAddr <= LOW_BASE  + (WIN_BYTES - 1));
  assign inHigh = (accAddr >= HIGH_BASE) && (accAddr <= HIGH_BASE + (WIN_BYTES - 1));

  a_r2_route_legal: assert property (@(posedge clk) disable iff (!rstN)
    route != 2'b11);

  a_r2_outside_unclaimed: assert property (@(posedge clk) disable iff (!rstN)
    (!inLow && !inHigh) |-> route == 2'b00);

  a_r3_closed_low_pci: assert property (@(posedge clk) disable iff (!rstN)
    (!smmAccess && inLow && !ctrlByte[6]) |-> route == 2'b10);

  a_r3_closed_high_none: assert property (@(posedge clk) disable iff (!rstN)
    (!smmAccess && inHigh && !ctrlByte[6]) |-> route == 2'b00);

  a_r7_fixed_bits: assert property (@(posedge clk) disable iff (!rstN)
    ((ctrlByte & 8'hA7) == (CTRL_DEFAULT & 8'hA7)) &&
    ((extByte & 8'h7F) == (EXT_DEFAULT & 8'h7F)));

  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ctrlByte[4] |=> ctrlByte[4]);

  a_r8_locked_closed: assert property (@(posedge clk) disable iff (!rstN)
    ctrlByte[4] |-> !ctrlByte[6]);

  a_r9_gen_frozen: assert property (@(posedge clk) disable iff (!rstN)
    ctrlByte[4] |=> $stable(ctrlByte[3]));

endmodule

bind smram_vis smram_vis_chk #(
  .ADDR_W(ADDR_W), .LOW_BASE(LOW_BASE), .HIGH_BASE(HIGH_BASE),
  .WIN_BYTES(WIN_BYTES), .CTRL_DEFAULT(CTRL_DEFAULT), .EXT_DEFAULT(EXT_DEFAULT)
) u_chk (
  .clk(clk), .rstN(rstN), .smmAccess(smmAccess), .accAddr(accAddr),
  .route(route), .ctrlByte(ctrlByte), .extByte(extByte)
);

// File: tb/smram_vis_test.sv
`timescale 1ns/1ps
module smram_vis_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgWrSel = 1'b0;
  logic [7:0]  cfgWrData = 8'h00;
  logic        smmAccess = 1'b0;
  logic [31:0] accAddr = 32'h0;
  logic [1:0]  route;
  logic [7:0]  ctrlByte, extByte;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] mCtrl, mExt;

  always #2 clk = ~clk;

  smram_vis uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel),
    .cfgWrData(cfgWrData), .smmAccess(smmAccess), .accAddr(accAddr),
    .route(route), .ctrlByte(ctrlByte), .extByte(extByte)
  );

  function automatic logic [1:0] expRoute(logic [7:0] c, logic [7:0] e, logic smm,
                                          logic [31:0] a);
    logic lo, hi, dram;
    lo = (a >= 32'h000A0000) && (a <= 32'h000BFFFF);
    hi = (a >= 32'hFEDA0000) && (a <= 32'hFEDBFFFF);
    if (lo) begin
      dram = (c[6] && !e[7]) || (smm && c[3] && !e[7]);
      return dram ? 2'b01 : 2'b10;
    end
    if (hi) begin
      dram = (c[6] && e[7]) || (smm && c[3] && e[7]);
      return dram ? 2'b01 : 2'b00;
    end
    return 2'b00;
  endfunction

  function automatic string tagFor(logic [7:0] c, logic smm, logic [31:0] a);
    logic lo, hi;
    lo = (a >= 32'h000A0000) && (a <= 32'h000BFFFF);
    hi = (a >= 32'hFEDA0000) && (a <= 32'hFEDBFFFF);
    if (!lo && !hi) return "R2";
    if (smm && c[3]) return "R5";
    if (smm) return "R6";
    if (c[6]) return "R4";
    return "R3";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    mCtrl = 8'h02;
    mExt  = 8'h00;
  endtask

  task automatic doWrite(logic sel, logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrSel = sel; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (!sel) begin
      if (!mCtrl[4]) begin
        mCtrl = (mCtrl & ~8'h58) | (d & 8'h58);
        if (d[4]) mCtrl[6] = 1'b0;
      end
    end else begin
      mExt = (mExt & ~8'h80) | (d & 8'h80);
    end
  endtask

  task automatic probe(string tag, logic smm, logic [31:0] a);
    @(negedge clk);
    smmAccess = smm; accAddr = a;
    #1;
    check(tag.len() ? tag : tagFor(mCtrl, smm, a), {30'd0, route},
          {30'd0, expRoute(mCtrl, mExt, smm, a)});
  endtask

  task automatic checkRegs(string tag);
    #1;
    check(tag, {24'd0, ctrlByte}, {24'd0, mCtrl});
    check(tag, {24'd0, extByte},  {24'd0, mExt});
  endtask

  function automatic logic [31:0] poolAddr(int k);
    case (k)
      0: return 32'h000A0000;  1: return 32'h000BFFFF;
      2: return 32'h0009FFFF;  3: return 32'h000C0000;
      4: return 32'hFEDA0000;  5: return 32'hFEDBFFFF;
      6: return 32'hFED9FFFF;  7: return 32'hFEDC0000;
      8: return 32'h000A5A5A;  9: return 32'hFEDB1234;
      10: return 32'h00000000; 11: return 32'hFFFFFFFF;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    doReset();
    // R1: reset values and routing
    #1;
    check("R1", {24'd0, ctrlByte}, 32'h02);
    check("R1", {24'd0, extByte}, 32'h00);
    probe("R1", 1'b0, 32'h000A0000);
    probe("R1", 1'b0, 32'hFEDA0000);

    // R10: window edges, with open set and each high-enable value
    doWrite(1'b0, 8'h40);
    for (int h = 0; h < 2; h++) begin
      doWrite(1'b1, h ? 8'h80 : 8'h00);
      for (int k = 0; k < 8; k++) probe("R10", 1'b0, poolAddr(k));
    end

    // R3..R6: every open / global-enable / high-enable combination
    for (int combo = 0; combo < 8; combo++) begin
      doWrite(1'b0, {1'b0, combo[0], 2'b00, combo[1], 3'b000});
      doWrite(1'b1, {combo[2], 7'h00});
      checkRegs("R7");
      for (int s = 0; s < 2; s++) begin
        probe("", s[0], 32'h000B0000);
        probe("", s[0], 32'hFEDA8000);
      end
    end

    // R7: read-only bits ignore writes; new value seen next cycle
    doWrite(1'b0, 8'hFF);
    checkRegs("R7");
    doReset();
    doWrite(1'b1, 8'h7F);
    checkRegs("R7");
    doWrite(1'b0, 8'h48);
    checkRegs("R7");
    probe("R7", 1'b0, 32'h000A0010);

    // R8: write that sets lock clears open; lock sticky; no reopen
    doWrite(1'b0, 8'h58);
    checkRegs("R8");
    check("R8", {31'd0, ctrlByte[6]}, 32'd0);
    doWrite(1'b0, 8'h40);
    checkRegs("R8");
    check("R8", {31'd0, ctrlByte[4]}, 32'd1);
    probe("R8", 1'b0, 32'h000A0000);
    // R9: global-enable frozen, extended byte still writable
    doWrite(1'b0, 8'h00);
    checkRegs("R9");
    check("R9", {31'd0, ctrlByte[3]}, 32'd1);
    doWrite(1'b1, 8'h80);
    checkRegs("R9");
    probe("R9", 1'b1, 32'hFEDA0000);
    // R1: reset releases lock
    doReset();
    checkRegs("R1");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      int op;
      if (i % 400 == 399) doReset();
      op = int'($urandom_range(0, 9));
      if (op < 2) doWrite($urandom_range(0, 1) == 1, 8'($urandom));
      else if (op < 3) begin @(negedge clk); checkRegs("R7"); end
      else probe("", $urandom_range(0, 1) == 1, poolAddr(int'($urandom_range(0, 14))));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule